// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Manager

This block holds a protection code for every erase block of a flash array and changes those codes when the host issues lock-type commands. Each block is in one of three states: unlocked, locked or lock-tight. Lock-tight is sticky. An unlock or lock walk stops when it meets a lock-tight block. A lock-tight walk leaves unlocked blocks as they are.

The host writes a start and an end block index. It then strobes a command opcode. The block walks the selected range one block per clock and writes each changed code into the block's entry. The last code written is copied into a status register. A busy flag covers the walk. A one-cycle done pulse, a completion flag and a sticky range-error flag report the outcome. A query port returns the code of any block. Enforcing the protection on program or erase traffic is left to other logic.

The index registers keep only the bits of the written value selected by `RANGE_MASK`. By default the mask is the block count minus one. A wider mask lets the host address indices beyond the array, and the range check catches these.

Top module: `wp_lock_mgr`

## Requirements
- R1: After reset every block reads the locked code, `wp_status` reads 0x0002, `busy`, `done`, `cmd_err` and `int_flag` are 0, and both index registers read 0.
- R2: Protection codes are one-hot on 3 bits: lock-tight is 3'b001, locked is 3'b010 and unlocked is 3'b100. `qry_code` returns the code of block `qry_idx`.
- R3: A `start_wr` stores `addr_wdata & RANGE_MASK` into the start index and the same value into the end index. An `end_wr` stores the masked value into the end index only. When both are strobed together, the end index takes the value from `end_wr`.
- R4: Opcode 0x23 (unlock) and opcode 0x2A (lock) walk from the start index up to the end index inclusive. They write unlocked or locked to each block in turn. The walk halts at the first lock-tight block and leaves that block and all later blocks unchanged. A start index above the end index changes nothing.
- R5: Opcode 0x2C (lock-tight) walks the same range. It skips blocks that are unlocked and writes lock-tight to every other block.
- R6: Opcode 0x27 (unlock all) walks from block 0 to the last block with the same halting rule as R4. It ignores the index registers.
- R7: Every block write also loads the written code into the low 3 bits of `wp_status`. A walk that writes nothing leaves `wp_status` unchanged.
- R8: A walk that reaches an index at or beyond `NUM_BLOCKS` sets `cmd_err` and ends. Blocks below that index are processed normally.
- R9: Each accepted command sets `int_flag` when its walk ends. `int_ack` clears `int_flag` and `cmd_err`. A completion in the same cycle as `int_ack` wins.
- R10: `busy` rises in the cycle after a command is accepted and stays high until the walk ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R11: An opcode other than the four above, or any strobe that arrives while `busy` is high, is ignored. No walk starts and no code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Write strobe for the start block index |
| end_wr | input | 1 | Write strobe for the end block index |
| addr_wdata | input | DATA_W | Value for the index writes |
| start_blk | output | IDX_W | Current start block index |
| end_blk | output | IDX_W | Current end block index |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| int_ack | input | 1 | Clears the completion and error flags |
| qry_idx | input | IDX_W | Block index to query |
| qry_code | output | 3 | Protection code of the queried block (0 if out of range) |
| wp_status | output | DATA_W | Last code written, zero-extended |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err | output | 1 | Sticky range error |
| int_flag | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check the following:
- The busy and done handshake: busy follows an accepted command, done is a single cycle and never overlaps busy.
- That the completion flag is up with done.
- That queried codes stay one-hot.
- That a start write copies into the end index.
- That each block write lands in the status register.
- That an ignored strobe never raises busy.

Which blocks a walk changes, where it halts or skips, and when the range error fires depend on the whole array history. Only the bench's scenarios show these. The bench sweeps every start and end pair of a 12-block array, including indices past the end. It compares every block against an arithmetic model after each command.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    WP_TIGHT    = 3'b001,
    WP_LOCKED   = 3'b010,
    WP_UNLOCKED = 3'b100
  } wp_code_e;

  typedef enum logic [1:0] {
    ACT_WRITE = 2'd0,
    ACT_SKIP  = 2'd1,
    ACT_HALT  = 2'd2
  } wp_act_e;

  localparam logic [7:0] OP_UNLOCK     = 8'h23;
  localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OP_LOCK       = 8'h2A;
  localparam logic [7:0] OP_TIGHT      = 8'h2C;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_UNLOCK) || (op == OP_UNLOCK_ALL) ||
           (op == OP_LOCK)   || (op == OP_TIGHT);
  endfunction

  function automatic logic [2:0] op_code(input logic [7:0] op);
    logic [2:0] c;
    case (op)
      OP_LOCK:  c = WP_LOCKED;
      OP_TIGHT: c = WP_TIGHT;
      default:  c = WP_UNLOCKED;
    endcase
    return c;
  endfunction

  function automatic wp_act_e step_action(input logic [7:0] op,
                                          input logic [2:0] cur);
    wp_act_e a;
    if (op == OP_TIGHT)
      a = (cur == WP_UNLOCKED) ? ACT_SKIP : ACT_WRITE;
    else
      a = (cur == WP_TIGHT) ? ACT_HALT : ACT_WRITE;
    return a;
  endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 16,
  parameter int RANGE_MASK = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              end_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  start_q,
  output logic [IDX_W-1:0]  end_q
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(RANGE_MASK);

  logic [IDX_W-1:0] masked;
  assign masked = IDX_W'(wdata & MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (start_wr) start_q <= masked;
      if (end_wr || start_wr) end_q <= masked;
    end
  end

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array #(
  parameter int NUM_BLOCKS = 64,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [2:0]       rd_code,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [2:0]       qry_code
);

  import wp_pkg::*;

  logic [2:0] mem [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= WP_LOCKED;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        mem[g] <= wr_code;
    end
  end

  always_comb begin
    rd_code  = '0;
    qry_code = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (rd_idx == IDX_W'(i))  rd_code  = mem[i];
      if (qry_idx == IDX_W'(i)) qry_code = mem[i];
    end
  end

endmodule

// File: rtl/wp_walker.sv
module wp_walker #(
  parameter int NUM_BLOCKS = 64,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] end_idx,
  input  logic [2:0]       cur_code,
  input  logic             int_ack,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [2:0]       wr_code,
  output logic [2:0]       stat_code,
  output logic             busy,
  output logic             done,
  output logic             cmd_err,
  output logic             int_flag,
  output logic             cmd_accept,
  output logic             walk_fin
);

  import wp_pkg::*;

  localparam int CW = IDX_W + 1;
  localparam logic [CW-1:0] LAST  = CW'(NUM_BLOCKS - 1);
  localparam logic [CW-1:0] COUNT = CW'(NUM_BLOCKS);

  logic [7:0]    op_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] lim_q;
  logic          past_end;
  logic          oob;
  logic          step_err;
  wp_act_e       act;

  assign past_end   = idx_q > lim_q;
  assign oob        = idx_q >= COUNT;
  assign act        = step_action(op_q, cur_code);
  assign rd_idx     = idx_q[IDX_W-1:0];
  assign wr_idx     = idx_q[IDX_W-1:0];
  assign wr_code    = op_code(op_q);
  assign wr_en      = busy && !past_end && !oob && (act == ACT_WRITE);
  assign step_err   = busy && !past_end && oob;
  assign walk_fin   = busy && (past_end || oob || (act == ACT_HALT));
  assign cmd_accept = cmd_valid && !busy && op_known(cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_q      <= '0;
      idx_q     <= '0;
      lim_q     <= '0;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      int_flag  <= 1'b0;
      stat_code <= WP_LOCKED;
    end else begin
      done <= walk_fin;
      if (cmd_accept) begin
        busy <= 1'b1;
        op_q <= cmd_op;
        if (cmd_op == OP_UNLOCK_ALL) begin
          idx_q <= '0;
          lim_q <= LAST;
        end else begin
          idx_q <= CW'(start_idx);
          lim_q <= CW'(end_idx);
        end
      end else if (busy) begin
        if (walk_fin) busy <= 1'b0;
        else          idx_q <= idx_q + 1'b1;
      end
      if (wr_en) stat_code <= wr_code;
      if (walk_fin)     int_flag <= 1'b1;
      else if (int_ack) int_flag <= 1'b0;
      if (step_err)     cmd_err <= 1'b1;
      else if (int_ack) cmd_err <= 1'b0;
    end
  end

endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr #(
  parameter int NUM_BLOCKS = 64,
  parameter int IDX_W      = $clog2(NUM_BLOCKS),
  parameter int DATA_W     = 16,
  parameter int RANGE_MASK = NUM_BLOCKS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              end_wr,
  input  logic [DATA_W-1:0] addr_wdata,
  output logic [IDX_W-1:0]  start_blk,
  output logic [IDX_W-1:0]  end_blk,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              int_ack,
  input  logic [IDX_W-1:0]  qry_idx,
  output logic [2:0]        qry_code,
  output logic [DATA_W-1:0] wp_status,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              int_flag
);

  logic [IDX_W-1:0] rd_idx;
  logic [2:0]       rd_code;
  logic             blk_wr_en;
  logic [IDX_W-1:0] blk_wr_idx;
  logic [2:0]       blk_wr_code;
  logic [2:0]       stat_code;
  logic             cmd_accept;
  logic             walk_fin;

  wp_range_regs #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .RANGE_MASK(RANGE_MASK)
  ) u_range (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
    .wdata(addr_wdata), .start_q(start_blk), .end_q(end_blk)
  );

  wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(blk_wr_en), .wr_idx(blk_wr_idx),
    .wr_code(blk_wr_code), .rd_idx(rd_idx), .rd_code(rd_code),
    .qry_idx(qry_idx), .qry_code(qry_code)
  );

  wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .start_idx(start_blk), .end_idx(end_blk), .cur_code(rd_code),
    .int_ack(int_ack), .rd_idx(rd_idx), .wr_en(blk_wr_en),
    .wr_idx(blk_wr_idx), .wr_code(blk_wr_code), .stat_code(stat_code),
    .busy(busy), .done(done), .cmd_err(cmd_err), .int_flag(int_flag),
    .cmd_accept(cmd_accept), .walk_fin(walk_fin)
  );

  assign wp_status = {{(DATA_W-3){1'b0}}, stat_code};

endmodule

// File: rtl/wp_lock_mgr_chk.sv
module wp_lock_mgr_chk #(
  parameter int NUM_BLOCKS = 64,
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_wr,
  input logic              end_wr,
  input logic [IDX_W-1:0]  start_blk,
  input logic [IDX_W-1:0]  end_blk,
  input logic              cmd_valid,
  input logic [IDX_W-1:0]  qry_idx,
  input logic [2:0]        qry_code,
  input logic [DATA_W-1:0] wp_status,
  input logic              busy,
  input logic              done,
  input logic              int_flag,
  input logic              cmd_accept,
  input logic              blk_wr_en,
  input logic [2:0]        blk_wr_code
);

  a_r2_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(qry_idx) < NUM_BLOCKS) |-> ($countones(qry_code) == 1));

  a_r3_end_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !end_wr) |=> (end_blk == start_blk));

  a_r7_status_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr_en |=> (wp_status[2:0] == $past(blk_wr_code)));

  a_r9_int_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int_flag);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_ignored_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !cmd_accept) |=> !busy);

endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
  .start_blk(start_blk), .end_blk(end_blk), .cmd_valid(cmd_valid),
  .qry_idx(qry_idx), .qry_code(qry_code), .wp_status(wp_status),
  .busy(busy), .done(done), .int_flag(int_flag), .cmd_accept(cmd_accept),
  .blk_wr_en(blk_wr_en), .blk_wr_code(blk_wr_code)
);

// File: tb/wp_lock_mgr_tb.sv
`timescale 1ns/1ps
module wp_lock_mgr_tb;

  localparam int NB = 12;
  localparam int IW = 4;
  localparam int DW = 16;
  localparam int MASK = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_wr = 1'b0, end_wr = 1'b0, cmd_valid = 1'b0, int_ack = 1'b0;
  logic [DW-1:0] addr_wdata = '0;
  logic [7:0]    cmd_op = '0;
  logic [IW-1:0] qry_idx = '0;
  logic [IW-1:0] start_blk, end_blk;
  logic [2:0]    qry_code;
  logic [DW-1:0] wp_status;
  logic          busy, done, cmd_err, int_flag;

  wp_lock_mgr #(.NUM_BLOCKS(NB), .IDX_W(IW), .DATA_W(DW), .RANGE_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
    .addr_wdata(addr_wdata), .start_blk(start_blk), .end_blk(end_blk),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .int_ack(int_ack),
    .qry_idx(qry_idx), .qry_code(qry_code), .wp_status(wp_status),
    .busy(busy), .done(done), .cmd_err(cmd_err), .int_flag(int_flag)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // expected state
  int e_code [NB];
  int e_stat, e_start, e_end;
  bit e_err, e_int;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) e_code[i] = 2;
    e_stat = 2; e_start = 0; e_end = 0; e_err = 0; e_int = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // arithmetic model of one command
  task automatic model_cmd(input logic [7:0] op);
    int lo, hi, tgt;
    lo = (op == 8'h27) ? 0 : e_start;
    hi = (op == 8'h27) ? NB - 1 : e_end;
    tgt = (op == 8'h2A) ? 2 : (op == 8'h2C) ? 1 : 4;
    for (int b = lo; b <= hi; b++) begin
      if (b >= NB) begin e_err = 1; break; end
      if (op == 8'h2C) begin
        if (e_code[b] == 4) continue;
      end else if (e_code[b] == 1) break;
      e_code[b] = tgt;
      e_stat = tgt;
    end
    e_int = 1;
  endtask

  task automatic wr_start(input int v);
    @(negedge clk); start_wr = 1'b1; addr_wdata = DW'(v);
    @(negedge clk); start_wr = 1'b0;
    e_start = v & MASK; e_end = v & MASK;
  endtask

  task automatic wr_end(input int v);
    @(negedge clk); end_wr = 1'b1; addr_wdata = DW'(v);
    @(negedge clk); end_wr = 1'b0;
    e_end = v & MASK;
  endtask

  task automatic run_cmd(input logic [7:0] op, input string req);
    int n;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
    model_cmd(op);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, "done seen", int'(done), 1);
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < NB; i++) begin
      qry_idx = IW'(i);
      #0.2;
      chk(int'(qry_code) == e_code[i], req, $sformatf("block %0d code", i),
          int'(qry_code), e_code[i]);
    end
    chk(int'(wp_status) == e_stat, req, "status", int'(wp_status), e_stat);
    chk(cmd_err == e_err, req, "cmd_err", int'(cmd_err), int'(e_err));
    chk(int_flag == e_int, req, "int_flag", int'(int_flag), int'(e_int));
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    e_err = 0; e_int = 0;
  endtask

  logic [7:0] ops [4] = '{8'h23, 8'h2A, 8'h2C, 8'h27};

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk(busy == 0 && done == 0, "R1", "busy/done", int'({busy, done}), 0);
    chk(start_blk == 0 && end_blk == 0, "R1", "indices",
        int'({start_blk, end_blk}), 0);

    // R6 unlock all from reset, R2/R7 unlocked code
    run_cmd(8'h27, "R6");
    check_state("R6");
    chk(int'(qry_code) == 4, "R2", "unlocked code", int'(qry_code), 4);
    ack();

    // R3 index writes
    wr_start(16'h0035);
    chk(int'(start_blk) == 5 && int'(end_blk) == 5, "R3", "start copy",
        int'({start_blk, end_blk}), 8'h55);
    wr_end(16'h002B);
    chk(int'(end_blk) == 11 && int'(start_blk) == 5, "R3", "end only",
        int'({start_blk, end_blk}), 8'h5B);
    @(negedge clk); start_wr = 1'b1; end_wr = 1'b1; addr_wdata = 16'h0003;
    @(negedge clk); start_wr = 1'b0; end_wr = 1'b0;
    e_start = 3; e_end = 3;
    chk(int'(end_blk) == 3, "R3", "both strobes", int'(end_blk), 3);

    // R4 lock 2..6, R5 tight 0..9 skipping unlocked, R4 halt
    wr_start(2); wr_end(6);
    run_cmd(8'h2A, "R4"); check_state("R4"); ack();
    wr_start(4); wr_end(5);
    run_cmd(8'h23, "R4"); check_state("R4"); ack();
    wr_start(0); wr_end(9);
    run_cmd(8'h2C, "R5"); check_state("R5");
    chk(e_stat == 1, "R7", "status tight", int'(wp_status), 1);
    ack();
    wr_start(4); wr_end(8);
    run_cmd(8'h23, "R4"); check_state("R4"); ack();
    run_cmd(8'h27, "R6"); check_state("R6"); ack();

    // R4 start above end: no change
    wr_start(7); wr_end(3);
    run_cmd(8'h2A, "R4"); check_state("R4"); ack();

    // R8 range error past the array
    wr_start(10); wr_end(13);
    run_cmd(8'h23, "R8"); check_state("R8");
    ack();
    check_state("R9");

    // R11 unknown opcode ignored
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'h55;
    @(negedge clk); cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy == 0 && done == 0, "R11", "unknown op idle", int'({busy, done}), 0);
      @(negedge clk);
    end
    check_state("R11");

    // R11 strobe during busy ignored; R10 busy timing
    do_reset();
    wr_start(0); wr_end(11);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'h23;
    @(negedge clk); cmd_op = 8'h2C;
    chk(busy == 1, "R10", "busy after accept", int'(busy), 1);
    @(negedge clk); cmd_valid = 1'b0;
    model_cmd(8'h23);
    begin
      int n = 0;
      while (!done && n < 100) begin
        chk(busy == 1, "R10", "busy during walk", int'(busy), 1);
        @(negedge clk); n++;
      end
      chk(busy == 0 && done == 1, "R10", "done ends busy", int'({busy, done}), 1);
      @(negedge clk);
      chk(done == 0, "R10", "done one cycle", int'(done), 0);
    end
    check_state("R11");
    // R9 completion wins over ack in the same cycle
    wr_start(3); wr_end(3);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 8'h2A;
    @(negedge clk); cmd_valid = 1'b0;
    model_cmd(8'h2A);
    // walk: accept edge, write edge, finish edge -> ack held over finish edge
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    chk(int_flag == 1, "R9", "set wins over ack", int'(int_flag), 1);
    ack();

    // near-exhaustive sweep of every start/end pair
    for (int s = 0; s < 16; s++) begin
      do_reset();
      for (int e = 0; e < 16; e++) begin
        wr_start(s); wr_end(e);
        run_cmd(ops[(s * 3 + e) % 4], "R4");
        check_state("R8");
        ack();
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule